// File: doc/BRIEF.md
# RV32I Next-PC and Branch Resolution Unit

This block decides where an RV32I core fetches next. From the current program counter, the decoded immediate, the two source operand values, the branch condition field and a two-bit control-flow kind, it computes the next PC, the return address to be written to the destination register, a taken flag and a flag for a redirect target that is not word aligned. All conditional comparisons are evaluated here. There are no delay slots, so a taken branch or jump redirects the very next fetch.

Every target comes from one adder. For jump-and-link-register the adder's base is rs1. For every other kind the base is the PC. The fall-through address PC+4 has its own incrementer, and that value is also the link value. The result is registered: the outputs describe the inputs that were present at the previous rising clock edge.

Top module: `npc_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `next_pc_o` = RESET_PC (default 0), with `taken_o`, `link_wr_o` and `misalign_o` all 0.
- R2: Each output reflects the inputs that were sampled at the previous rising edge. The latency is exactly one cycle.
- R3: When `kind_i` = 2'b00 (sequential), `next_pc_o` = `pc_i`+4, and `taken_o` and `link_wr_o` are both 0.
- R4: When `kind_i` = 2'b10 (jump and link), `next_pc_o` = `pc_i`+`imm_i` (modulo 2^32) and `taken_o` = 1.
- R5: When `kind_i` = 2'b11 (jump and link register), `next_pc_o` = (`rs1_i`+`imm_i`) with bit 0 cleared, and `taken_o` = 1.
- R6: `link_o` always equals `pc_i`+4. `link_wr_o` is 1 exactly for kinds 2'b10 and 2'b11.
- R7: When `kind_i` = 2'b01 (conditional branch), `funct3_i` 3'b000 is taken when rs1 equals rs2, and 3'b001 is taken when they differ.
- R8: For a conditional branch, `funct3_i` 3'b100 is taken when rs1 < rs2 as signed two's-complement values, and 3'b101 is taken when rs1 >= rs2 as signed values.
- R9: For a conditional branch, `funct3_i` 3'b110 is taken when rs1 < rs2 as unsigned values, and 3'b111 is taken when rs1 >= rs2 as unsigned values.
- R10: For a conditional branch, the unused codes 3'b010 and 3'b011 are never taken.
- R11: A taken conditional branch gives `next_pc_o` = `pc_i`+`imm_i`. A branch that is not taken gives `pc_i`+4. `link_wr_o` is 0 in both cases.
- R12: `misalign_o` is 1 exactly when `taken_o` is 1 and bit 1 of `next_pc_o` is 1. It is never set on fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Current program counter |
| imm_i | input | 32 | Sign-extended immediate (J, I or B type) |
| rs1_i | input | 32 | First source operand value |
| rs2_i | input | 32 | Second source operand value |
| funct3_i | input | 3 | Branch condition code |
| kind_i | input | 2 | 00 sequential, 01 branch, 10 jump and link, 11 jump and link register |
| next_pc_o | output | 32 | Registered next program counter |
| link_o | output | 32 | Registered return address (PC+4) |
| link_wr_o | output | 1 | Registered destination-register write enable for the link |
| taken_o | output | 1 | Registered redirect flag |
| misalign_o | output | 1 | Registered misaligned-target flag |

## Verification
A jump produces a redirect and a link write in the same cycle. The bench drives both jump kinds with arbitrary PCs, so the target and the return address are checked together against a behavioural model. A second overlap is a redirect whose target has bit 1 set. That case occurs when the misaligned-target flag coincides with a taken branch or jump. The bench provokes it by choosing immediates that are multiples of 2 but not of 4. On every clock the bench compares all five outputs with the model's values, which come from the inputs of the previous cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    parameter int XLEN     = 32;
    parameter int INSN_LEN = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'b00,
        FLOW_BRANCH = 2'b01,
        FLOW_JAL    = 2'b10,
        FLOW_JALR   = 2'b11
    } flow_kind_e;

    typedef enum logic [2:0] {
        COND_EQ  = 3'b000,
        COND_NE  = 3'b001,
        COND_LT  = 3'b100,
        COND_GE  = 3'b101,
        COND_LTU = 3'b110,
        COND_GEU = 3'b111
    } cond_code_e;

    typedef struct packed {
        word_t next_pc;
        word_t link;
        logic  link_wr;
        logic  taken;
        logic  misalign;
    } flow_result_t;

    function automatic logic is_jump(flow_kind_e k);
        return (k == FLOW_JAL) || (k == FLOW_JALR);
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  word_t      a_i,
    input  word_t      b_i,
    input  logic [2:0] code_i,
    output logic       holds_o
);
    logic equal;
    logic less_s;
    logic less_u;

    assign equal  = (a_i == b_i);
    assign less_u = (a_i < b_i);
    assign less_s = ($signed(a_i) < $signed(b_i));

    always_comb begin
        case (code_i)
            COND_EQ:  holds_o = equal;
            COND_NE:  holds_o = !equal;
            COND_LT:  holds_o = less_s;
            COND_GE:  holds_o = !less_s;
            COND_LTU: holds_o = less_u;
            COND_GEU: holds_o = !less_u;
            default:  holds_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
(
    input  flow_kind_e kind_i,
    input  word_t      pc_i,
    input  word_t      rs1_i,
    input  word_t      imm_i,
    output word_t      target_o
);
    word_t base;
    word_t sum;
    logic  reg_rel;

    assign reg_rel = (kind_i == FLOW_JALR);
    assign base    = reg_rel ? rs1_i : pc_i;
    assign sum     = base + imm_i;
    assign target_o = reg_rel ? {sum[XLEN-1:1], 1'b0} : sum;
endmodule

// File: rtl/npc_redirect_sel.sv
module npc_redirect_sel
    import npc_pkg::*;
(
    input  flow_kind_e   kind_i,
    input  word_t        pc_i,
    input  word_t        target_i,
    input  logic         cond_ok_i,
    output flow_result_t res_o
);
    word_t seq_pc;
    logic  redirect;

    assign seq_pc   = pc_i + word_t'(INSN_LEN);
    assign redirect = is_jump(kind_i) || ((kind_i == FLOW_BRANCH) && cond_ok_i);

    always_comb begin
        res_o.link     = seq_pc;
        res_o.link_wr  = is_jump(kind_i);
        res_o.taken    = redirect;
        res_o.next_pc  = redirect ? target_i : seq_pc;
        res_o.misalign = redirect && target_i[1];
    end
endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pc_i,
    input  logic [31:0] imm_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    input  logic [2:0]  funct3_i,
    input  logic [1:0]  kind_i,
    output logic [31:0] next_pc_o,
    output logic [31:0] link_o,
    output logic        link_wr_o,
    output logic        taken_o,
    output logic        misalign_o
);
    flow_kind_e   kind;
    word_t        target;
    logic         cond_ok;
    flow_result_t comb_res;
    flow_result_t res_q;

    assign kind = flow_kind_e'(kind_i);

    npc_cond_eval u_cond (
        .a_i     (rs1_i),
        .b_i     (rs2_i),
        .code_i  (funct3_i),
        .holds_o (cond_ok)
    );

    npc_target_gen u_tgt (
        .kind_i   (kind),
        .pc_i     (pc_i),
        .rs1_i    (rs1_i),
        .imm_i    (imm_i),
        .target_o (target)
    );

    npc_redirect_sel u_sel (
        .kind_i    (kind),
        .pc_i      (pc_i),
        .target_i  (target),
        .cond_ok_i (cond_ok),
        .res_o     (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q.next_pc  <= RESET_PC;
            res_q.link     <= '0;
            res_q.link_wr  <= 1'b0;
            res_q.taken    <= 1'b0;
            res_q.misalign <= 1'b0;
        end else begin
            res_q <= comb_res;
        end
    end

    assign next_pc_o  = res_q.next_pc;
    assign link_o     = res_q.link;
    assign link_wr_o  = res_q.link_wr;
    assign taken_o    = res_q.taken;
    assign misalign_o = res_q.misalign;
endmodule

module npc_branch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_i,
    input logic [31:0] imm_i,
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [2:0]  funct3_i,
    input logic [1:0]  kind_i,
    input logic [31:0] next_pc_o,
    input logic [31:0] link_o,
    input logic        link_wr_o,
    input logic        taken_o,
    input logic        misalign_o
);
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!taken_o && !link_wr_o && !misalign_o)); // R1

    AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (primed || !rst) && $past(!rst) && $past(kind_i) == 2'b00
        |-> (next_pc_o == $past(pc_i) + 32'd4) && !taken_o && !link_wr_o); // R3

    AST_JAL_TARGET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(kind_i) == 2'b10
        |-> (next_pc_o == $past(pc_i) + $past(imm_i)) && taken_o); // R4

    AST_JALR_EVEN: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(kind_i) == 2'b11
        |-> !next_pc_o[0] && taken_o); // R5

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (link_o == $past(pc_i) + 32'd4)
                     && (link_wr_o == $past(kind_i[1]))); // R6

    AST_BEQ_RESOLVE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(kind_i) == 2'b01 && $past(funct3_i) == 3'b000
        |-> taken_o == $past(rs1_i == rs2_i)); // R7

    AST_RSVD_COND: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(kind_i) == 2'b01 && $past(funct3_i[2:1]) == 2'b01
        |-> !taken_o && next_pc_o == $past(pc_i) + 32'd4); // R10

    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
        primed |-> misalign_o == (taken_o && next_pc_o[1])); // R12
endmodule

bind npc_branch_unit npc_branch_unit_chk u_chk (.*);

// File: tb/npc_branch_unit_test.sv
module npc_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pc_i, imm_i, rs1_i, rs2_i;
    logic [2:0]  funct3_i;
    logic [1:0]  kind_i;
    logic [31:0] next_pc_o, link_o;
    logic        link_wr_o, taken_o, misalign_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [31:0] e_pc, e_link;
    logic        e_wr, e_tk, e_mis;
    string       e_tag;
    bit          have_exp = 0;

    always #10 clk = ~clk;

    npc_branch_unit uut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .imm_i(imm_i), .rs1_i(rs1_i),
        .rs2_i(rs2_i), .funct3_i(funct3_i), .kind_i(kind_i),
        .next_pc_o(next_pc_o), .link_o(link_o), .link_wr_o(link_wr_o),
        .taken_o(taken_o), .misalign_o(misalign_o)
    );

    task automatic model(input logic [31:0] pc, imm, a, b, input logic [2:0] f3,
                         input logic [1:0] k);
        longint sa, sb;
        bit     c;
        logic [31:0] t;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        c = 0;
        e_link = pc + 32'd4;
        e_wr   = (k == 2'b10) || (k == 2'b11);
        case (k)
            2'b00: begin e_tag = "R3"; e_tk = 0; t = pc + 32'd4; end
            2'b10: begin e_tag = "R4"; e_tk = 1; t = pc + imm; end
            2'b11: begin e_tag = "R5"; e_tk = 1; t = (a + imm) & 32'hFFFF_FFFE; end
            default: begin
                case (f3)
                    3'b000: begin c = (a == b);  e_tag = "R7"; end
                    3'b001: begin c = (a != b);  e_tag = "R7"; end
                    3'b100: begin c = (sa < sb); e_tag = "R8"; end
                    3'b101: begin c = (sa >= sb); e_tag = "R8"; end
                    3'b110: begin c = (a < b);   e_tag = "R9"; end
                    3'b111: begin c = (a >= b);  e_tag = "R9"; end
                    default: begin c = 0;        e_tag = "R10"; end
                endcase
                e_tk = c;
                t = c ? pc + imm : pc + 32'd4; // R11
            end
        endcase
        e_pc  = t;
        e_mis = e_tk && t[1];
    endtask

    task automatic compare();
        bit bad;
        bad = 0;
        vectors++;
        if (next_pc_o !== e_pc) begin
            $display("FAIL %s/R11 next_pc actual=%h expected=%h", e_tag, next_pc_o, e_pc); bad = 1;
        end
        if (taken_o !== e_tk) begin
            $display("FAIL %s taken actual=%0b expected=%0b", e_tag, taken_o, e_tk); bad = 1;
        end
        if (link_o !== e_link || link_wr_o !== e_wr) begin
            $display("FAIL R6 link actual=%h/%0b expected=%h/%0b", link_o, link_wr_o, e_link, e_wr); bad = 1;
        end
        if (misalign_o !== e_mis) begin
            $display("FAIL R12 misalign actual=%0b expected=%0b", misalign_o, e_mis); bad = 1;
        end
        if (bad) errors++;
    endtask

    // R2: the values driven at one falling edge are checked at the next falling edge
    task automatic apply(input logic [31:0] pc, imm, a, b, input logic [2:0] f3,
                         input logic [1:0] k);
        @(negedge clk);
        if (have_exp) compare();
        pc_i = pc; imm_i = imm; rs1_i = a; rs2_i = b; funct3_i = f3; kind_i = k;
        model(pc, imm, a, b, f3, k);
        have_exp = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pc_i = 32'h1234_5678; imm_i = 32'h10; rs1_i = 0; rs2_i = 0;
        funct3_i = 0; kind_i = 2'b10;
        repeat (3) @(negedge clk);
        vectors++;
        if (next_pc_o !== 32'h0 || taken_o !== 0 || link_wr_o !== 0 || misalign_o !== 0) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%0b/%0b/%0b expected=0/0/0/0",
                     next_pc_o, taken_o, link_wr_o, misalign_o);
        end
        rst = 1'b0;

        // R3 sequential, including wrap at the top of the address space
        apply(32'h0000_0100, 32'h40, 1, 2, 3'b000, 2'b00);
        apply(32'hFFFF_FFFC, 32'h0, 0, 0, 3'b000, 2'b00);
        // R4 jumps and links forward and backward, misaligned by 2 (R12)
        apply(32'h0000_1000, 32'h0000_0020, 0, 0, 3'b000, 2'b10);
        apply(32'h0000_1000, 32'hFFFF_FFF0, 0, 0, 3'b000, 2'b10);
        apply(32'h0000_1000, 32'h0000_0006, 0, 0, 3'b000, 2'b10);
        // R5 register-relative jumps: bit 0 cleared, bit 1 flagged
        apply(32'h0000_2000, 32'h0000_0001, 32'h0000_8000, 0, 3'b000, 2'b11);
        apply(32'h0000_2000, 32'hFFFF_FFFF, 32'h0000_8004, 0, 3'b000, 2'b11);
        apply(32'h0000_2000, 32'h0000_0003, 32'h0000_8000, 0, 3'b000, 2'b11);
        // R7 equality
        apply(32'h300, 32'h80, 32'd5, 32'd5, 3'b000, 2'b01);
        apply(32'h300, 32'h80, 32'd5, 32'd6, 3'b000, 2'b01);
        apply(32'h300, 32'h80, 32'd5, 32'd6, 3'b001, 2'b01);
        apply(32'h300, 32'h80, 32'd5, 32'd5, 3'b001, 2'b01);
        // R8 signed and R9 unsigned with a negative operand
        apply(32'h400, 32'hFFFF_FF00, 32'hFFFF_FFFF, 32'd1, 3'b100, 2'b01);
        apply(32'h400, 32'hFFFF_FF00, 32'hFFFF_FFFF, 32'd1, 3'b101, 2'b01);
        apply(32'h400, 32'h0000_0102, 32'hFFFF_FFFF, 32'd1, 3'b110, 2'b01);
        apply(32'h400, 32'h0000_0102, 32'hFFFF_FFFF, 32'd1, 3'b111, 2'b01);
        apply(32'h400, 32'h10, 32'd7, 32'd7, 3'b101, 2'b01);
        apply(32'h400, 32'h10, 32'd7, 32'd7, 3'b111, 2'b01);
        apply(32'h400, 32'h10, 32'h8000_0000, 32'h7FFF_FFFF, 3'b100, 2'b01);
        apply(32'h400, 32'h10, 32'h8000_0000, 32'h7FFF_FFFF, 3'b110, 2'b01);
        // R10 unused codes with operands that would satisfy any condition
        apply(32'h500, 32'h10, 32'd3, 32'd3, 3'b010, 2'b01);
        apply(32'h500, 32'h10, 32'd1, 32'd9, 3'b011, 2'b01);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 5 == 0) ? a : $urandom;
            apply($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFE, a, b,
                  3'($urandom), 2'($urandom));
        end
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule